// File: doc/BRIEF.md
# Multi-Sector Erase Command Sequencer

This block is the command front end of a NOR-style parallel flash device, limited to sector erase. Software writes a fixed six-step sequence: five unlock steps and then an erase opcode aimed at any address inside a sector. That opens an acceptance window. Each further erase opcode written while the window is open adds a sector to the erase set and restarts the window. When the window runs out, a timed erase phase begins. Its length is proportional to the number of distinct sectors queued.

While the block is busy, reads return polling status instead of array data:

- bit 3 tells the window (0) apart from the erase phase (1);
- bit 7 reads 0;
- bit 6 flips on every read strobe.

At completion the block emits one done strobe per queued sector, lowest sector first. The array behind it (which does the actual clearing) uses these strobes. All timing is counted in clock cycles and set by parameters.

Top module: `sector_erase_seq`

## Requirements
- R1: The erase sequence is accepted only in this exact form: 0xAA to address 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, then 0x30 to any address. The sector index is the address with its low SECT_BITS bits dropped (addr[ADDR_W-1:SECT_BITS]).
- R2: A write that does not match the expected unlock step (wrong data or address, including 0xF0) returns the decoder to its first step. Nothing is queued, and reads keep returning array data.
- R3: After the edge that accepts an erase opcode, status bit 3 reads 0 for exactly WIN_CYC cycles and then reads 1.
- R4: A write of 0x30 while the window is open adds that sector to the set and restarts the WIN_CYC window from that edge.
- R5: Any other write during the window aborts the operation. From the next cycle reads return array data, the erase set is emptied and no done strobe follows.
- R6: The erase phase lasts K × 2^ERASE_EXP × MS_CYC cycles, where K is the number of distinct queued sectors. A sector written twice counts once.
- R7: Writes during the erase phase and during done signalling are ignored and do not change timing or the done strobes.
- R8: While busy, read data is status: bit 7 = 0, bit 6 = a toggle that inverts after each cycle with the read strobe high, bit 3 as in R3, all other bits 0. A read strobe while idle has no visible effect.
- R9: Starting the cycle after the erase phase ends, erase_done is high for one cycle per queued sector, on consecutive cycles. done_sector carries the sector indices in ascending order. The cycle after the last strobe, reads return array data and the next erase starts from an empty set.
- R10: After reset, read data equals array data and erase_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the bus access |
| bus_wdata | input | 8 | Write data / command byte |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| array_rdata | input | 8 | Data from the storage array |
| rd_data | output | 8 | Array data when idle, polling status when busy |
| erase_done | output | 1 | One-cycle strobe per erased sector |
| done_sector | output | ADDR_W-SECT_BITS | Sector index qualified by erase_done |

## Verification
Status reads are combinational from registered state, so the bench samples them at the falling edge right after the accepting write. Bit 3 is due to rise exactly WIN_CYC edges after the last accepted 0x30. The first done strobe is due K × 2^ERASE_EXP × MS_CYC edges after that, plus one more edge, and the remaining strobes follow back to back. The bench counts its falling edges against these figures and samples precisely on the predicted cycles, one cycle early and one cycle late included. Any shortening or stretching of the window or the erase phase therefore shows up as a mismatch.

// File: rtl/esq_pkg.sv
package esq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WIN   = 2'd1,
    PH_ERASE = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;

  localparam logic [7:0] K_UNLK1 = 8'hAA;
  localparam logic [7:0] K_UNLK2 = 8'h55;
  localparam logic [7:0] K_SETUP = 8'h80;
  localparam logic [7:0] K_SECT  = 8'h30;

endpackage

// File: rtl/esq_unlock.sv
module esq_unlock #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] A_FIRST  = ADDR_W'('h555),
  parameter logic [ADDR_W-1:0] A_SECOND = ADDR_W'('h2AA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              arm
);
  import esq_pkg::*;

  logic [2:0] st_q, st_d;
  logic       st_en;

  always_comb begin
    st_d = st_q;
    arm  = 1'b0;
    if (!enable) begin
      st_d = 3'd0;
    end else if (we) begin
      case (st_q)
        3'd0: st_d = (addr == A_FIRST  && wdata == K_UNLK1) ? 3'd1 : 3'd0;
        3'd1: st_d = (addr == A_SECOND && wdata == K_UNLK2) ? 3'd2 : 3'd0;
        3'd2: st_d = (addr == A_FIRST  && wdata == K_SETUP) ? 3'd3 : 3'd0;
        3'd3: st_d = (addr == A_FIRST  && wdata == K_UNLK1) ? 3'd4 : 3'd0;
        3'd4: st_d = (addr == A_SECOND && wdata == K_UNLK2) ? 3'd5 : 3'd0;
        3'd5: begin
          st_d = 3'd0;
          arm  = (wdata == K_SECT);
        end
        default: st_d = 3'd0;
      endcase
    end
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= 3'd0;
    else if (st_en) st_q <= st_d;
  end

  AST_UNLOCK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_q == 3'd0)); // R2

endmodule

// File: rtl/esq_timer.sv
module esq_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);
  assign cnt_d  = load ? load_val : (cnt_q - W'(1));
  assign expire = (cnt_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/esq_drain.sv
module esq_drain #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SECT_BITS = 8,
  parameter int unsigned WIN_CYC   = 50,
  parameter int unsigned MS_CYC    = 20,
  parameter int unsigned ERASE_EXP = 1,
  parameter int unsigned TMR_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [7:0]                  bus_wdata,
  input  logic                        bus_we,
  input  logic                        bus_re,
  input  logic [7:0]                  array_rdata,
  output logic [7:0]                  rd_data,
  output logic                        erase_done,
  output logic [ADDR_W-SECT_BITS-1:0] done_sector
);
  import esq_pkg::*;

  localparam int unsigned SEC_W     = ADDR_W - SECT_BITS;
  localparam int unsigned NUM_SECT  = 1 << SEC_W;
  localparam int unsigned CNT_W     = $clog2(NUM_SECT + 1);
  localparam int unsigned ERASE_CYC = (1 << ERASE_EXP) * MS_CYC;

  phase_e              phase_q, phase_d;
  logic [NUM_SECT-1:0] bitmap_q, bitmap_d;
  logic [CNT_W-1:0]    count_q, count_d;
  logic                toggle_q, toggle_en;
  logic                done_q, done_d;
  logic [SEC_W-1:0]    dsec_q, dsec_d;
  logic                state_en;

  logic                arm, tmr_load, tmr_exp;
  logic [TMR_W-1:0]    tmr_val;
  logic [SEC_W-1:0]    sec_idx;
  logic                win_add, win_abort;
  logic                drn_found;
  logic [SEC_W-1:0]    drn_idx;
  logic [7:0]          status;

  assign sec_idx   = bus_addr[ADDR_W-1:SECT_BITS];
  assign win_add   = (phase_q == PH_WIN) && bus_we && (bus_wdata == K_SECT);
  assign win_abort = (phase_q == PH_WIN) && bus_we && (bus_wdata != K_SECT);

  esq_unlock #(
    .ADDR_W   (ADDR_W),
    .A_FIRST  (ADDR_W'('h555)),
    .A_SECOND (ADDR_W'('h2AA))
  ) u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (phase_q == PH_IDLE),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .arm    (arm)
  );

  esq_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_exp)
  );

  esq_drain #(.N(NUM_SECT), .IDX_W(SEC_W)) u_drain (
    .bits  (bitmap_q),
    .found (drn_found),
    .idx   (drn_idx)
  );

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    bitmap_d = bitmap_q;
    count_d  = count_q;
    done_d   = 1'b0;
    dsec_d   = dsec_q;
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(WIN_CYC);
    case (phase_q)
      PH_IDLE: begin
        if (arm) begin
          phase_d           = PH_WIN;
          bitmap_d          = '0;
          bitmap_d[sec_idx] = 1'b1;
          count_d           = CNT_W'(1);
          tmr_load          = 1'b1;
        end
      end
      PH_WIN: begin
        if (win_abort) begin
          phase_d  = PH_IDLE;
          bitmap_d = '0;
          count_d  = '0;
        end else if (win_add) begin
          bitmap_d[sec_idx] = 1'b1;
          if (!bitmap_q[sec_idx]) count_d = count_q + CNT_W'(1);
          tmr_load = 1'b1;
        end else if (tmr_exp) begin
          phase_d  = PH_ERASE;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(count_q) * TMR_W'(ERASE_CYC);
        end
      end
      PH_ERASE: begin
        if (tmr_exp) phase_d = PH_DRAIN;
      end
      PH_DRAIN: begin
        if (drn_found) begin
          done_d            = 1'b1;
          dsec_d            = drn_idx;
          bitmap_d[drn_idx] = 1'b0;
          count_d           = count_q - CNT_W'(1);
        end else begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign state_en  = (phase_d != phase_q) || (bitmap_d != bitmap_q) ||
                     (count_d != count_q) || (dsec_d != dsec_q);
  assign toggle_en = (phase_q != PH_IDLE) && bus_re;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bitmap_q <= '0;
      count_q  <= '0;
      dsec_q   <= '0;
    end else if (state_en) begin
      phase_q  <= phase_d;
      bitmap_q <= bitmap_d;
      count_q  <= count_d;
      dsec_q   <= dsec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         toggle_q <= 1'b0;
    else if (toggle_en) toggle_q <= ~toggle_q;
  end

  assign status      = {1'b0, toggle_q, 2'b00, (phase_q != PH_WIN), 3'b000};
  assign rd_data     = (phase_q == PH_IDLE) ? array_rdata : status;
  assign erase_done  = done_q;
  assign done_sector = dsec_q;

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_q) == $countones(bitmap_q)); // R6
  AST_WIN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WIN) |-> (bitmap_q != '0)); // R4
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    win_abort |=> (phase_q == PH_IDLE && bitmap_q == '0)); // R5
  AST_ERASE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ERASE) |=> (phase_q == PH_ERASE || phase_q == PH_DRAIN)); // R7
  AST_DONE_FROM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |-> ($past(phase_q) == PH_DRAIN)); // R9
  AST_DONE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_done && $past(erase_done)) |-> (done_sector > $past(done_sector))); // R9

endmodule

// File: tb/sim_sector_erase_seq.sv
`timescale 1ns/1ps
module sim_sector_erase_seq;
  localparam int ADDR_W = 12;
  localparam int SECT_BITS = 8;
  localparam int WIN_CYC = 50;
  localparam int MS_CYC = 20;
  localparam int ERASE_EXP = 1;
  localparam int SEC_W = ADDR_W - SECT_BITS;
  localparam int NSEC = 1 << SEC_W;
  localparam int ERASE_CYC = (1 << ERASE_EXP) * MS_CYC;

  logic clk = 1'b0;
  logic rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_we, bus_re;
  logic [7:0] array_rdata;
  logic [7:0] rd_data;
  logic erase_done;
  logic [SEC_W-1:0] done_sector;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [ADDR_W-1:0] w_addr [4];
  int w_gap [4];
  int w_n;

  always #2.5 clk = ~clk;

  sector_erase_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .array_rdata(array_rdata),
    .rd_data(rd_data), .erase_done(erase_done), .done_sector(done_sector)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_pulse();
    bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  function automatic logic [NSEC-1:0] exp_set();
    logic [NSEC-1:0] s = '0;
    for (int i = 0; i < w_n; i++) s[w_addr[i][ADDR_W-1:SECT_BITS]] = 1'b1;
    return s;
  endfunction

  // runs a full erase of the w_* writes; inject adds ignored writes and a status read
  task automatic run_erase(input bit inject);
    logic [NSEC-1:0] s;
    int dur, used;
    logic t0;
    s = exp_set();
    dur = $countones(s) * ERASE_CYC;
    array_rdata = 8'($urandom);
    unlock();
    for (int i = 0; i < w_n; i++) begin
      wr(w_addr[i], 8'h30);
      if (i < w_n - 1) begin
        for (int g = 0; g < w_gap[i]; g++) begin
          @(negedge clk);
          chk(rd_data[3] == 1'b0, "R4 window held open", rd_data, 0);
        end
      end
    end
    chk(rd_data[3] == 1'b0 && (rd_data & 8'hB7) == 8'h00, "R3 window status", rd_data, 0);
    repeat (WIN_CYC - 1) @(negedge clk);
    chk(rd_data[3] == 1'b0, "R3 last window cycle", rd_data[3], 0);
    @(negedge clk);
    chk(rd_data[3] == 1'b1 && rd_data[7] == 1'b0, "R3 erase status", rd_data, 8'h08);
    used = 0;
    if (inject) begin
      wr(12'h555, 8'hF0);
      wr({~w_addr[0][ADDR_W-1:SECT_BITS], 8'h00}, 8'h30);
      t0 = rd_data[6];
      rd_pulse();
      chk(rd_data[6] == ~t0, "R8 toggle on read", rd_data[6], ~t0);
      rd_pulse();
      chk(rd_data[6] == t0, "R8 toggle back", rd_data[6], t0);
      used = 4;
    end
    repeat (dur - used) @(negedge clk);
    chk(erase_done == 1'b0 && rd_data[3] == 1'b1, "R6 erase not ended early", erase_done, 0);
    for (int k = 0; k < NSEC; k++) begin
      if (s[k]) begin
        @(negedge clk);
        chk(erase_done == 1'b1 && done_sector == SEC_W'(k), "R9 done strobe order",
            {erase_done, done_sector}, {1'b1, SEC_W'(k)});
      end
    end
    @(negedge clk);
    chk(erase_done == 1'b0 && rd_data == array_rdata, "R9 back to array",
        rd_data, array_rdata);
    if (inject) chk(1'b1, "R7 ignored writes kept timing", 0, 0);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (erase_done) seen = 1;
      if (rd_data != array_rdata) bad = 1;
    end
    chk(!seen && !bad, req, {seen, bad}, 0);
  endtask

  initial begin
    int seed;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
    bus_addr = '0; bus_wdata = '0; array_rdata = 8'h3C;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk(rd_data == 8'h3C && erase_done == 1'b0, "R10 reset state", rd_data, 8'h3C);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h3C, "R10 idle after reset", rd_data, 8'h3C);

    // R8: read strobe while idle
    rd_pulse(); rd_pulse();
    chk(rd_data == 8'h3C, "R8 idle read no effect", rd_data, 8'h3C);

    // R1 R7: single sector, low address bits arbitrary, ignored writes during erase
    w_n = 1; w_addr[0] = 12'h7A5;
    run_erase(1'b1);
    chk(1'b1, "R1 sequence accepted", 0, 0);

    // R4 R6: duplicates and both boundary sectors
    w_n = 4;
    w_addr[0] = 12'h5FF; w_gap[0] = 10;
    w_addr[1] = 12'hF00; w_gap[1] = WIN_CYC - 5;
    w_addr[2] = 12'h012; w_gap[2] = 0;
    w_addr[3] = 12'h510;
    run_erase(1'b0);

    // R5: abort during window, then a clean erase of another sector
    array_rdata = 8'hA7;
    unlock();
    wr(12'h333, 8'h30);
    repeat (5) @(negedge clk);
    wr(12'h555, 8'hF0);
    chk(rd_data == array_rdata, "R5 abort returns array", rd_data, array_rdata);
    quiet(WIN_CYC + 4 * ERASE_CYC, "R5 no strobe after abort");
    w_n = 1; w_addr[0] = 12'h900;
    run_erase(1'b0);

    // R2: sequence errors
    array_rdata = 8'h11;
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    wr(12'h400, 8'h30);
    quiet(WIN_CYC + 5, "R2 wrong command byte");
    wr(12'h123, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h400, 8'h30);
    quiet(WIN_CYC + 5, "R2 wrong unlock address");
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hF0); wr(12'h2AA, 8'h55); wr(12'h400, 8'h30);
    quiet(WIN_CYC + 5, "R2 reset byte mid sequence");

    // random batches
    for (int it = 0; it < 8; it++) begin
      w_n = 1 + int'($urandom_range(3));
      for (int i = 0; i < 4; i++) begin
        w_addr[i] = ADDR_W'($urandom);
        w_gap[i] = int'($urandom_range(WIN_CYC - 3));
      end
      run_erase(it[0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule